// File: doc/BRIEF.md
# Debug Trace Capture Buffer

This block is a circular trace store for on-chip debug. It holds 256 entries of 64 bits. Once software or a start pulse arms it, each cycle with a valid event stores the 64-bit event word at the write pointer, and the pointer then advances. Three single-cycle pulses drive a set of sticky status flags. A start pulse arms capture. A trigger pulse records that the watched event has fired. A stop pulse freezes capture. A wrapped flag records that entry 255 has been filled at least once.

Software reaches the store through a 32-bit register port with four words. An access-control word selects an entry index and issues a read or write command. Two data words hold the low and high 32-bit halves of one entry. A status word reports the flags and the live write pointer. The storage has a single port, so hardware capture always wins it. A software read or write waits while capture uses the port and completes in the first cycle that capture leaves the port free. While an access waits, the status word shows a busy bit.

The status word can be written only while capture is off, meaning the buffer is not armed or has already been stopped. Such a write loads the flags and the write pointer in one go, so an all-zero write prepares a clean run starting at entry 0.

Top module: `dbg_trace_store`

## Requirements
- R1: After reset, the access-control word, both data words and the status word read 0: flags clear, write pointer 0, index 0, no access pending.
- R2: When the armed flag is set, the stopped flag is clear and `capValid` is high in a cycle, `capData` is stored at the write pointer and the pointer increases by 1 modulo 256. Flag updates from pulses apply from the next cycle, so a capture in the same cycle as a stop pulse still happens.
- R3: The wrapped flag sets when a capture writes entry 255, and it stays set until a status write that is accepted.
- R4: The `startPulse`, `trigPulse` and `stopPulse` inputs each set a sticky flag: armed, triggered and stopped. Once the stopped flag is set, `capValid` stores nothing and leaves the pointer unchanged.
- R5: A status write is accepted only while capture is off (armed clear or stopped set). An accepted write loads the four flags from bits 3:0 and the write pointer from bits 31:24. At any other time the status write changes nothing.
- R6: Register addresses are 0 for access control, 1 for data low, 2 for data high and 3 for status. The status word layout is: bit 0 armed, bit 1 triggered, bit 2 stopped, bit 3 wrapped, bit 4 busy (a software access is pending), bits 31:24 the write pointer, and all other bits 0.
- R7: A write to access control loads the index from bits 31:24. It requests a read if bit 0 is set; otherwise it arms a write command if bit 1 is set. It also cancels any pending access. Reading access control returns the index in bits 31:24, the pending-read flag in bit 0 and the armed-write flag in bit 1.
- R8: A pending read copies entry bits 31:0 into data low and entry bits 63:32 into data high, in the first cycle without a capture.
- R9: After a write command, a write to data high queues a commit. The commit stores {data high, data low} at the index in the first cycle without a capture, and then ends the write command.
- R10: Hardware capture has priority over software access to the storage. At most one storage access happens per cycle, and a waiting software access keeps the busy bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Arm-capture event pulse |
| trigPulse | input | 1 | Trigger event pulse |
| stopPulse | input | 1 | Stop-capture event pulse |
| capValid | input | 1 | Event word valid this cycle |
| capData | input | 64 | Event word to record |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word select |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for the selected word, combinational |

## Verification
A wrong write pointer shows up in the status word in the very next cycle. It also surfaces later as the wrong entries when the buffer is read back. A lost priority decision or a lost pending bit appears either as a busy bit that clears too early or too late, or as data words that change in a cycle where capture held the port. A flag that fails to stick, or a status write that is not ignored, changes the status word in the cycle right after the stimulus. The bench therefore compares the selected register against a behavioural model on every cycle.

// File: rtl/dbg_trace_pkg.sv
package dbg_trace_pkg;
  localparam int unsigned TB_AW    = 8;
  localparam int unsigned TB_WORD  = 64;
  localparam int unsigned TB_REG_W = 32;

  typedef enum logic [1:0] {
    REG_ACC  = 2'd0,
    REG_LO   = 2'd1,
    REG_HI   = 2'd2,
    REG_STAT = 2'd3
  } regSelT;

  typedef struct packed {
    logic             capWr;
    logic             swWr;
    logic             swRd;
    logic             ldLo;
    logic             ldHi;
    logic [TB_AW-1:0] wrPtr;
    logic [TB_AW-1:0] swIdx;
  } tbStrobeT;
endpackage

// File: rtl/dbg_trace_data.sv
module dbg_trace_data
  import dbg_trace_pkg::*;
#(
  parameter int unsigned AW    = TB_AW,
  parameter int unsigned WORD  = TB_WORD,
  parameter int unsigned REG_W = TB_REG_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  tbStrobeT         strb,
  input  logic [WORD-1:0]  capData,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] loWord,
  output logic [REG_W-1:0] hiWord
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned HALF  = WORD / 2;

  logic [WORD-1:0] store [DEPTH];
  logic [WORD-1:0] wrWord;
  logic [AW-1:0]   wrAddr;
  logic            wrEn;

  always_comb begin
    wrEn   = strb.capWr | strb.swWr;
    wrAddr = strb.capWr ? strb.wrPtr : strb.swIdx;
    wrWord = strb.capWr ? capData : {hiWord[HALF-1:0], loWord[HALF-1:0]};
  end

  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loWord <= '0;
      hiWord <= '0;
    end else if (strb.swRd) begin
      loWord <= REG_W'(store[strb.swIdx][HALF-1:0]);
      hiWord <= REG_W'(store[strb.swIdx][WORD-1:HALF]);
    end else begin
      if (strb.ldLo) loWord <= regWrData;
      if (strb.ldHi) hiWord <= regWrData;
    end
  end

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.capWr, strb.swWr, strb.swRd})); // R10
  AST_LO_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capWr && !strb.ldLo) |=> $stable(loWord)); // R10
endmodule

// File: rtl/dbg_trace_ctrl.sv
module dbg_trace_ctrl
  import dbg_trace_pkg::*;
#(
  parameter int unsigned AW    = TB_AW,
  parameter int unsigned REG_W = TB_REG_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             trigPulse,
  input  logic             stopPulse,
  input  logic             capValid,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  logic [REG_W-1:0] loWord,
  input  logic [REG_W-1:0] hiWord,
  output tbStrobeT         strb,
  output logic [REG_W-1:0] regRdData
);
  localparam int unsigned IDX_LSB = REG_W - AW;
  localparam int unsigned NFLAG   = 4;

  logic [NFLAG-1:0] flags;        // 0 armed, 1 triggered, 2 stopped, 3 wrapped
  logic [NFLAG-1:0] flagSet;
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    swIdx;
  logic             pendRd, pendWr, wrArmed;
  logic             accSel, loSel, hiSel, statSel;
  logic             captureOn, capWr, rdSvc, wrSvc, statusWrOk;

  always_comb begin
    accSel     = regWrEn && (regSelT'(regAddr) == REG_ACC);
    loSel      = regWrEn && (regSelT'(regAddr) == REG_LO);
    hiSel      = regWrEn && (regSelT'(regAddr) == REG_HI);
    statSel    = regWrEn && (regSelT'(regAddr) == REG_STAT);
    captureOn  = flags[0] && !flags[2];
    capWr      = captureOn && capValid;
    rdSvc      = pendRd && !capWr;
    wrSvc      = pendWr && !capWr;
    statusWrOk = statSel && !captureOn;
    flagSet    = {capWr && (wrPtr == '1), stopPulse, trigPulse, startPulse};
  end

  generate
    for (genvar f = 0; f < NFLAG; f++) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rstN) flags[f] <= 1'b0;
        else       flags[f] <= (statusWrOk ? regWrData[f] : flags[f]) | flagSet[f];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
    end else if (capWr) begin
      wrPtr <= wrPtr + 1'b1;
    end else if (statusWrOk) begin
      wrPtr <= regWrData[REG_W-1:IDX_LSB];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swIdx   <= '0;
      pendRd  <= 1'b0;
      pendWr  <= 1'b0;
      wrArmed <= 1'b0;
    end else if (accSel) begin
      swIdx   <= regWrData[REG_W-1:IDX_LSB];
      pendRd  <= regWrData[0];
      wrArmed <= regWrData[1] && !regWrData[0];
      pendWr  <= 1'b0;
    end else begin
      if (rdSvc) pendRd <= 1'b0;
      if (wrSvc) begin
        pendWr  <= 1'b0;
        wrArmed <= 1'b0;
      end else if (hiSel && wrArmed) begin
        pendWr <= 1'b1;
      end
    end
  end

  always_comb begin
    strb.capWr = capWr;
    strb.swWr  = wrSvc;
    strb.swRd  = rdSvc;
    strb.ldLo  = loSel;
    strb.ldHi  = hiSel;
    strb.wrPtr = wrPtr;
    strb.swIdx = swIdx;
  end

  always_comb begin
    regRdData = '0;
    unique case (regSelT'(regAddr))
      REG_ACC: begin
        regRdData[REG_W-1:IDX_LSB] = swIdx;
        regRdData[1:0]             = {wrArmed, pendRd};
      end
      REG_LO:  regRdData = loWord;
      REG_HI:  regRdData = hiWord;
      REG_STAT: begin
        regRdData[REG_W-1:IDX_LSB] = wrPtr;
        regRdData[4]               = pendRd | pendWr;
        regRdData[NFLAG-1:0]       = flags;
      end
    endcase
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    capWr |=> (wrPtr == AW'($past(wrPtr) + 1'b1))); // R2
  AST_PTR_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (captureOn && !capWr) |=> $stable(wrPtr)); // R5
  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flags[3] && !statusWrOk) |=> flags[3]); // R3
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (flags[2] && !statusWrOk) |=> $stable(wrPtr)); // R4
  AST_HELD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (pendRd && capWr && !accSel) |=> pendRd); // R10
endmodule

// File: rtl/dbg_trace_store.sv
module dbg_trace_store
  import dbg_trace_pkg::*;
#(
  parameter int unsigned AW    = TB_AW,
  parameter int unsigned WORD  = TB_WORD,
  parameter int unsigned REG_W = TB_REG_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             trigPulse,
  input  logic             stopPulse,
  input  logic             capValid,
  input  logic [WORD-1:0]  capData,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData
);
  tbStrobeT         strb;
  logic [REG_W-1:0] loWord, hiWord;

  dbg_trace_ctrl #(.AW(AW), .REG_W(REG_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .startPulse(startPulse), .trigPulse(trigPulse), .stopPulse(stopPulse),
    .capValid(capValid),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .loWord(loWord), .hiWord(hiWord),
    .strb(strb), .regRdData(regRdData)
  );

  dbg_trace_data #(.AW(AW), .WORD(WORD), .REG_W(REG_W)) i_data (
    .clk(clk), .rstN(rstN),
    .strb(strb), .capData(capData), .regWrData(regWrData),
    .loWord(loWord), .hiWord(hiWord)
  );
endmodule

// File: tb/test_dbg_trace_store.sv
module test_dbg_trace_store;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 0, trigPulse = 0, stopPulse = 0, capValid = 0;
  logic [63:0] capData = '0;
  logic        regWrEn = 0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  // behavioural reference state
  logic [63:0] mMem [int];
  bit   mArm, mTrig, mStop, mWrap, mPendRd, mPendWr, mWrArm;
  int   mPtr, mIdx;
  logic [31:0] mLo, mHi;

  dbg_trace_store i_dbg_trace_store (
    .clk(clk), .rstN(rstN),
    .startPulse(startPulse), .trigPulse(trigPulse), .stopPulse(stopPulse),
    .capValid(capValid), .capData(capData),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] modelRead(input logic [1:0] a);
    logic [31:0] r = '0;
    case (a)
      2'd0: begin r[31:24] = 8'(mIdx); r[1] = mWrArm; r[0] = mPendRd; end
      2'd1: r = mLo;
      2'd2: r = mHi;
      default: begin
        r[31:24] = 8'(mPtr); r[4] = mPendRd | mPendWr;
        r[3:0] = {mWrap, mStop, mTrig, mArm};
      end
    endcase
    return r;
  endfunction

  task automatic modelReset();
    mArm = 0; mTrig = 0; mStop = 0; mWrap = 0;
    mPendRd = 0; mPendWr = 0; mWrArm = 0;
    mPtr = 0; mIdx = 0; mLo = '0; mHi = '0;
  endtask

  task automatic modelEdge();
    bit on = mArm && !mStop;
    bit cap = on && capValid;
    bit rdS = mPendRd && !cap;
    bit wrS = mPendWr && !cap;
    bit stOk = regWrEn && regAddr == 2'd3 && !on;
    int oldPtr = mPtr;
    logic [63:0] rdWord = '0;
    if (rdS) rdWord = mMem.exists(mIdx) ? mMem[mIdx] : 64'h0;
    if (cap) mMem[oldPtr] = capData;
    if (wrS) mMem[mIdx] = {mHi, mLo};
    if (rdS) begin mLo = rdWord[31:0]; mHi = rdWord[63:32]; end
    else begin
      if (regWrEn && regAddr == 2'd1) mLo = regWrData;
      if (regWrEn && regAddr == 2'd2) mHi = regWrData;
    end
    if (stOk) begin
      mArm = regWrData[0]; mTrig = regWrData[1];
      mStop = regWrData[2]; mWrap = regWrData[3];
      mPtr = regWrData[31:24];
    end
    if (cap) mPtr = (oldPtr + 1) % 256;
    mArm |= startPulse; mTrig |= trigPulse; mStop |= stopPulse;
    if (cap && oldPtr == 255) mWrap = 1;
    if (regWrEn && regAddr == 2'd0) begin
      mIdx = regWrData[31:24]; mPendRd = regWrData[0];
      mWrArm = regWrData[1] && !regWrData[0]; mPendWr = 0;
    end else begin
      if (rdS) mPendRd = 0;
      if (wrS) begin mPendWr = 0; mWrArm = 0; end
      else if (regWrEn && regAddr == 2'd2 && mWrArm) mPendWr = 1;
    end
  endtask

  // one cycle: drive, compare the selected word, then advance model at the edge
  task automatic step(input bit st, input bit tg, input bit sp, input bit cv,
                      input logic [63:0] cd, input bit we, input logic [1:0] a,
                      input logic [31:0] wd, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    startPulse = st; trigPulse = tg; stopPulse = sp; capValid = cv; capData = cd;
    regWrEn = we; regAddr = a; regWrData = wd;
    #1;
    exp = modelRead(a);
    compared++;
    if (regRdData !== exp) begin
      mismatched++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, regRdData, exp);
    end
    @(posedge clk);
    modelEdge();
  endtask

  task automatic look(input logic [1:0] a, input string tag);
    step(0, 0, 0, 0, 64'h0, 0, a, 32'h0, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
    step(0, 0, 0, 0, 64'h0, 1, a, d, tag);
  endtask

  task automatic cap(input int n, input string tag);
    step(0, 0, 0, 1, {32'hC0DE0000 + 32'(n), 32'(n * 7 + 1)}, 0, 2'd3, 32'h0, tag);
  endtask

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1: reset state of every word
    look(2'd3, "R1"); look(2'd0, "R1"); look(2'd1, "R1"); look(2'd2, "R1");
    // R5: preload pointer while idle
    wr(2'd3, 32'hFA00_0000, "R5");
    look(2'd3, "R5");
    // R4: arm
    step(1, 0, 0, 0, 64'h0, 0, 2'd3, 32'h0, "R4");
    look(2'd3, "R4");
    // R2/R3: captures across entry 255 with gaps
    for (int k = 0; k < 12; k++) begin
      if (k % 4 == 3) look(2'd3, "R2");
      else cap(k, "R2");
    end
    look(2'd3, "R3");
    // R5: status write while armed is ignored
    wr(2'd3, 32'h1100_0000, "R5");
    look(2'd3, "R5");
    // R4: trigger flag
    step(0, 1, 0, 0, 64'h0, 0, 2'd3, 32'h0, "R4");
    look(2'd3, "R6");
    // R10: read of entry 251 held off by continuous capture
    wr(2'd0, 32'hFB00_0001, "R7");
    for (int k = 20; k < 24; k++) cap(k, "R10");
    look(2'd3, "R10");
    look(2'd1, "R8"); look(2'd2, "R8");
    // R4: stop with a capture in the same cycle, then capture is frozen
    step(0, 0, 1, 1, 64'h5151_5151_A0A0_A0A0, 0, 2'd3, 32'h0, "R4");
    for (int k = 30; k < 33; k++) cap(k, "R4");
    look(2'd3, "R4");
    // R9: software write to entry 7 then read back
    wr(2'd0, 32'h0700_0002, "R7");
    look(2'd0, "R7");
    wr(2'd1, 32'h1234_5678, "R9");
    wr(2'd2, 32'h9ABC_DEF0, "R9");
    look(2'd3, "R9");
    look(2'd0, "R9");
    wr(2'd1, 32'h0, "R9"); wr(2'd2, 32'h0, "R9");
    wr(2'd0, 32'h0700_0001, "R8");
    look(2'd0, "R8");
    look(2'd1, "R9"); look(2'd2, "R9");
    // R3/R8: read entries on both sides of the wrap
    for (int e = 0; e < 5; e++) begin
      wr(2'd0, {8'(e == 4 ? 255 : e), 24'h000001}, "R8");
      look(2'd1, "R3"); look(2'd2, "R3");
    end
    // R7: both command bits -> read wins
    wr(2'd0, 32'h0200_0003, "R7");
    look(2'd0, "R7");
    look(2'd0, "R7");
    // R5/R6: clean restart after stop
    wr(2'd3, 32'h0, "R5");
    look(2'd3, "R6");
    // R2: capture again from 0 after re-arm
    step(1, 0, 0, 0, 64'h0, 0, 2'd3, 32'h0, "R2");
    cap(40, "R2"); cap(41, "R2");
    look(2'd3, "R2");
    wr(2'd0, 32'h0100_0001, "R8");
    look(2'd1, "R8"); look(2'd2, "R8");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        mismatched++;
        $display("FAIL watchdog actual=%0d expected<=5000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end
endmodule